// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer

A single 16-bit counter that is switched, through a small register write port, between four behaviours: an interval timer that counts a prescaled tick and reloads when it passes zero, an event counter that counts rising edges of an external pin (single-phase with a programmed direction, or two-phase quadrature where the phase relationship picks the direction), a one-shot that runs for one programmed period after a trigger, and a pulse-width modulator that runs either as one 16-bit modulator or as an 8-bit modulator behind an 8-bit prescaler. All modes take their period or width from one shared reload register.

The count-source tick, the external pins and the trigger are assumed already synchronised to `clk` and prescaled by the surrounding logic. The counter value is visible at all times on `cnt_val`. Every wrap, and the end of a one-shot, gives a one-clock interrupt pulse. Software should change the mode only while the start bit is clear.

Top module: `tmr16_multi`

## Requirements
- R1: After reset the counter, the reload value and the control field are zero, and `pin_out` and `irq` are low.
- R2: A write to address 0 sets the control field (bits 1:0 mode with 0 timer, 1 event, 2 one-shot, 3 PWM; bit 2 start; bit 3 count up; bit 4 quadrature; bit 5 8-bit PWM). A write to address 1 sets the reload value, and while start is clear the counter takes that value one clock after the write. Writes to addresses 2 and 3 have no effect.
- R3: While start is clear the counter holds its value (except the load of R2), `pin_out` is low, no interrupt is raised, and any running one-shot or PWM is cancelled.
- R4: In timer mode each tick decrements the counter. A tick at zero reloads it, toggles `pin_out` and raises the interrupt, so the period is reload+1 ticks.
- R5: In event mode without quadrature each rising edge of `ext_a` counts up when the up bit is set and down otherwise, and ticks are ignored. Counting up from 0xFFFF or down from 0 reloads the counter, toggles `pin_out` and raises the interrupt.
- R6: In event mode with quadrature a rising edge of `ext_a` counts up when `ext_b` is low and down when `ext_b` is high, whatever the up bit holds.
- R7: In one-shot mode a rising `trig` edge while idle, with a nonzero reload n, loads n and drives `pin_out` high. After n ticks `pin_out` falls, the interrupt is raised and the counter returns to n. Trigger edges during the run are ignored.
- R8: In 16-bit PWM mode a rising `trig` edge clears the counter and starts it. Each tick advances it through 0..0xFFFE and then wraps it, raising the interrupt on the wrap. `pin_out` is high while the counter is below the reload value, giving n high ticks in every 65535.
- R9: In 8-bit PWM mode the counter's upper byte divides ticks by reload[15:8]+1 and its lower byte steps through 0..0xFE. The interrupt is raised when the lower byte wraps, and `pin_out` is high while the lower byte is below reload[7:0].
- R10: `irq` is a one-clock pulse in the clock after the counting event that caused it, and `cnt_val` always shows the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 reload) |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Prescaled count-source enable |
| ext_a | input | 1 | Event input / first quadrature phase |
| ext_b | input | 1 | Second quadrature phase |
| trig | input | 1 | One-shot and PWM start trigger |
| cnt_val | output | 16 | Live counter value |
| pin_out | output | 1 | Timer pin output |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The interval timer runs both with a tick on every clock and with sparse ticks, which separates a design that counts the tick from one that counts the clock. Event mode runs across the 0xFFFF wrap counting up and across zero counting down, with ticks toggling throughout, so that a tick leaking into the count shows. Quadrature runs with the up bit set against the sign that `ext_b` selects, and the one-shot gets a second trigger during its run. Both PWM widths run for a full period and beyond, so the wrap point and the high-time comparison are each checked at the boundary. A cycle-by-cycle model compares every output on every clock.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_PWM     = 2'd3
  } tmr_mode_e;

  // Control field, bit 5 down to bit 0.
  typedef struct packed {
    logic      pwm8;
    logic      quad;
    logic      up;
    logic      start;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int CTL_W = 6;
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output tmr_ctl_t     ctl,
  output logic [W-1:0] reload,
  output logic         reload_ld
);
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_RLD = 2'd1;

  logic unused_hi;
  assign unused_hi = ^wr_data[W-1:CTL_W];

  logic wr_ctl, wr_rld;
  assign wr_ctl = wr_en && (wr_addr == ADDR_CTL);
  assign wr_rld = wr_en && (wr_addr == ADDR_RLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl       <= '0;
      reload    <= '0;
      reload_ld <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= tmr_ctl_t'(wr_data[CTL_W-1:0]);
      if (wr_rld) reload <= wr_data;
      reload_ld <= wr_rld;
    end
  end

  // R2: reload register follows a write to address 1
  a_r2_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rld |=> (reload == $past(wr_data)) && reload_ld);
endmodule

// File: rtl/tmr16_edge.sv
module tmr16_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  input  logic trig,
  input  logic quad,
  input  logic up,
  output logic ev_up,
  output logic ev_dn,
  output logic trig_rise
);
  logic a_q, t_q;
  logic a_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      t_q <= 1'b0;
    end else begin
      a_q <= in_a;
      t_q <= trig;
    end
  end

  assign a_rise    = in_a && !a_q;
  assign trig_rise = trig && !t_q;

  always_comb begin
    if (quad) begin
      ev_up = a_rise && !in_b;
      ev_dn = a_rise &&  in_b;
    end else begin
      ev_up = a_rise &&  up;
      ev_dn = a_rise && !up;
    end
  end

  // R5: an edge event needs the input to have been low one clock before
  a_r5_edge_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up || ev_dn) |-> !$past(in_a));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_ctl_t     ctl,
  input  logic [W-1:0] reload,
  input  logic         reload_ld,
  input  logic         tick,
  input  logic         ev_up,
  input  logic         ev_dn,
  input  logic         trig_rise,
  output logic [W-1:0] cnt,
  output logic         pin,
  output logic         irq
);
  localparam int          HALF  = W / 2;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] PMAX = CMAX - ONE;
  localparam logic [HALF-1:0] LONE  = HALF'(1);
  localparam logic [HALF-1:0] LPMAX = {HALF{1'b1}} - LONE;

  // Next PWM phase: {wrap, next count}
  function automatic logic [W:0] pwm_step(input logic [W-1:0] c,
                                          input logic [W-1:0] r,
                                          input logic eight);
    logic [HALF-1:0] hi, lo;
    logic wrap;
    wrap = 1'b0;
    hi   = c[W-1:HALF];
    lo   = c[HALF-1:0];
    if (!eight) begin
      if (c >= PMAX) return {1'b1, ZERO};
      return {1'b0, c + ONE};
    end
    if (hi >= r[W-1:HALF]) begin
      hi = '0;
      if (lo >= LPMAX) begin
        lo   = '0;
        wrap = 1'b1;
      end else begin
        lo = lo + LONE;
      end
    end else begin
      hi = hi + LONE;
    end
    return {wrap, hi, lo};
  endfunction

  // High phase of the modulator
  function automatic logic pwm_high(input logic [W-1:0] c,
                                    input logic [W-1:0] r,
                                    input logic eight);
    if (eight) return c[HALF-1:0] < r[HALF-1:0];
    return c < r;
  endfunction

  logic         tog, run;
  logic [W-1:0] nxt_cnt;
  logic         nxt_tog, nxt_run, fire;
  logic [W:0]   pstep;

  assign pstep = pwm_step(cnt, reload, ctl.pwm8);

  always_comb begin
    nxt_cnt = cnt;
    nxt_tog = tog;
    nxt_run = run;
    fire    = 1'b0;
    if (!ctl.start) begin
      nxt_tog = 1'b0;
      nxt_run = 1'b0;
      if (reload_ld) nxt_cnt = reload;
    end else begin
      unique case (ctl.mode)
        MODE_TIMER: begin
          if (tick) begin
            if (cnt == ZERO) begin
              nxt_cnt = reload;
              nxt_tog = !tog;
              fire    = 1'b1;
            end else begin
              nxt_cnt = cnt - ONE;
            end
          end
        end
        MODE_EVENT: begin
          if (ev_up) begin
            if (cnt == CMAX) begin
              nxt_cnt = reload;
              nxt_tog = !tog;
              fire    = 1'b1;
            end else begin
              nxt_cnt = cnt + ONE;
            end
          end else if (ev_dn) begin
            if (cnt == ZERO) begin
              nxt_cnt = reload;
              nxt_tog = !tog;
              fire    = 1'b1;
            end else begin
              nxt_cnt = cnt - ONE;
            end
          end
        end
        MODE_ONESHOT: begin
          if (!run) begin
            if (trig_rise && (reload != ZERO)) begin
              nxt_cnt = reload;
              nxt_run = 1'b1;
            end
          end else if (tick) begin
            if (cnt == ONE) begin
              nxt_cnt = reload;
              nxt_run = 1'b0;
              fire    = 1'b1;
            end else begin
              nxt_cnt = cnt - ONE;
            end
          end
        end
        MODE_PWM: begin
          if (!run) begin
            if (trig_rise) begin
              nxt_cnt = ZERO;
              nxt_run = 1'b1;
            end
          end else if (tick) begin
            nxt_cnt = pstep[W-1:0];
            fire    = pstep[W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
      run <= 1'b0;
      irq <= 1'b0;
    end else begin
      cnt <= nxt_cnt;
      tog <= nxt_tog;
      run <= nxt_run;
      irq <= fire;
    end
  end

  always_comb begin
    pin = 1'b0;
    if (ctl.start) begin
      unique case (ctl.mode)
        MODE_TIMER, MODE_EVENT: pin = tog;
        MODE_ONESHOT:           pin = run;
        MODE_PWM:               pin = run && pwm_high(cnt, reload, ctl.pwm8);
        default:                pin = 1'b0;
      endcase
    end
  end

  // R3: a stopped counter holds unless a reload load is pending
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.start && !reload_ld) |=> $stable(cnt));

  // R4: a tick at zero in timer mode reloads and interrupts
  a_r4_timer_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.start && ctl.mode == MODE_TIMER && tick && cnt == ZERO)
      |=> (cnt == $past(reload)) && irq);

  // R5: an up event below the top steps the counter by one
  a_r5_event_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.start && ctl.mode == MODE_EVENT && ev_up && cnt != CMAX)
      |=> cnt == $past(cnt) + ONE);

  // R7: the last one-shot tick ends the run with an interrupt
  a_r7_end_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.start && ctl.mode == MODE_ONESHOT && run && tick && cnt == ONE)
      |=> irq && !run);

  // R8: the 16-bit modulator never reaches the all-ones count
  a_r8_pwm_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.start && ctl.mode == MODE_PWM && !ctl.pwm8 && run) |-> cnt <= PMAX);
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
  import tmr16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        tick,
  input  logic        ext_a,
  input  logic        ext_b,
  input  logic        trig,
  output logic [15:0] cnt_val,
  output logic        pin_out,
  output logic        irq
);
  localparam int W = 16;

  tmr_ctl_t     ctl;
  logic [W-1:0] reload;
  logic         reload_ld;
  logic         ev_up, ev_dn, trig_rise;

  tmr16_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctl       (ctl),
    .reload    (reload),
    .reload_ld (reload_ld)
  );

  tmr16_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_a      (ext_a),
    .in_b      (ext_b),
    .trig      (trig),
    .quad      (ctl.quad),
    .up        (ctl.up),
    .ev_up     (ev_up),
    .ev_dn     (ev_dn),
    .trig_rise (trig_rise)
  );

  tmr16_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .reload    (reload),
    .reload_ld (reload_ld),
    .tick      (tick),
    .ev_up     (ev_up),
    .ev_dn     (ev_dn),
    .trig_rise (trig_rise),
    .cnt       (cnt_val),
    .pin       (pin_out),
    .irq       (irq)
  );

  // R10: at most one direction of event at a time
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_up && ev_dn));
endmodule

// File: tb/tb_tmr16_multi.sv
module tb_tmr16_multi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        tick = 1'b0;
  logic        ext_a = 1'b0;
  logic        ext_b = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] cnt_val;
  logic        pin_out;
  logic        irq;

  always #5 clk = ~clk;

  tmr16_multi dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .ext_a(ext_a), .ext_b(ext_b),
    .trig(trig), .cnt_val(cnt_val), .pin_out(pin_out), .irq(irq)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string phase = "R1";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_rl, m_mode;
  bit m_start, m_up, m_quad, m_p8, m_run, m_tog, m_irq, m_ld, pa, pt;

  function automatic bit m_pin();
    if (!m_start) return 0;
    if (m_mode <= 1) return m_tog;
    if (m_mode == 2) return m_run;
    if (m_p8) return m_run && ((m_cnt % 256) < (m_rl % 256));
    return m_run && (m_cnt < m_rl);
  endfunction

  always @(posedge clk) begin
    bit fire, ra, rt, cup, cdn;
    int hi, lo;
    fire = 0;
    if (!rst_n) begin
      m_cnt = 0; m_rl = 0; m_mode = 0; m_start = 0; m_up = 0; m_quad = 0;
      m_p8 = 0; m_run = 0; m_tog = 0; m_irq = 0; m_ld = 0; pa = 0; pt = 0;
    end else begin
      ra = ext_a && !pa;
      rt = trig && !pt;
      cup = m_quad ? (ra && !ext_b) : (ra && m_up);
      cdn = m_quad ? (ra && ext_b) : (ra && !m_up);
      if (!m_start) begin
        m_run = 0; m_tog = 0;
        if (m_ld) m_cnt = m_rl;
      end else if (m_mode == 0) begin
        if (tick) begin
          if (m_cnt == 0) begin m_cnt = m_rl; fire = 1; m_tog = !m_tog; end
          else m_cnt--;
        end
      end else if (m_mode == 1) begin
        if (cup) begin
          if (m_cnt == 65535) begin m_cnt = m_rl; fire = 1; m_tog = !m_tog; end
          else m_cnt++;
        end else if (cdn) begin
          if (m_cnt == 0) begin m_cnt = m_rl; fire = 1; m_tog = !m_tog; end
          else m_cnt--;
        end
      end else if (m_mode == 2) begin
        if (!m_run) begin
          if (rt && m_rl != 0) begin m_cnt = m_rl; m_run = 1; end
        end else if (tick) begin
          m_cnt--;
          if (m_cnt == 0) begin m_cnt = m_rl; m_run = 0; fire = 1; end
        end
      end else begin
        if (!m_run) begin
          if (rt) begin m_cnt = 0; m_run = 1; end
        end else if (tick) begin
          if (!m_p8) begin
            m_cnt = (m_cnt + 1) % 65535;
            fire = (m_cnt == 0);
          end else begin
            hi = m_cnt / 256; lo = m_cnt % 256;
            if (hi == m_rl / 256) begin
              hi = 0; lo = (lo + 1) % 255; fire = (lo == 0);
            end else hi++;
            m_cnt = hi * 256 + lo;
          end
        end
      end
      m_irq = fire;
      m_ld = wr_en && wr_addr == 2'd1;
      if (wr_en && wr_addr == 2'd0) begin
        m_mode = wr_data[1:0]; m_start = wr_data[2]; m_up = wr_data[3];
        m_quad = wr_data[4]; m_p8 = wr_data[5];
      end
      if (m_ld) m_rl = wr_data;
      pa = ext_a; pt = trig;
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cnt_val == m_cnt[15:0], phase, "cnt_val (R10)", cnt_val, m_cnt);
      check(pin_out == m_pin(), phase, "pin_out", pin_out, m_pin());
      check(irq == m_irq, phase, "irq (R10)", irq, m_irq);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctlw(input int mode, input bit st,
                                       input bit up, input bit qd, input bit p8);
    return {10'd0, p8, qd, up, st, 2'(mode)};
  endfunction

  task automatic pulse_a();
    @(negedge clk); ext_a = 1'b1;
    @(negedge clk); ext_a = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int hits, irqs;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cnt_val == 0 && pin_out == 0 && irq == 0, "R1", "reset outputs",
          {cnt_val, pin_out, irq}, 0);

    // R2: reload load while stopped
    phase = "R2";
    wr(2'd1, 16'd5);
    @(negedge clk);
    check(cnt_val == 16'd5, "R2", "counter loaded", cnt_val, 5);

    // R4: timer, tick every clock
    phase = "R4";
    tick = 1'b1;
    wr(2'd0, ctlw(0, 1, 0, 0, 0));
    irqs = 0;
    repeat (30) begin @(negedge clk); if (irq) irqs++; end
    check(irqs == 5, "R4", "timer wraps in 30 ticks", irqs, 5);
    // sparse ticks
    tick = 1'b0;
    repeat (20) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end

    // R3: stop freezes and drives pin low
    phase = "R3";
    wr(2'd0, ctlw(0, 0, 0, 0, 0));
    held = cnt_val;
    tick = 1'b1;
    repeat (10) @(negedge clk);
    check(cnt_val == held, "R3", "frozen counter", cnt_val, held);
    check(pin_out == 1'b0, "R3", "pin low when stopped", pin_out, 0);
    // R2: addresses 2 and 3 ignored
    phase = "R2";
    wr(2'd2, 16'h0004);
    wr(2'd3, 16'h1234);
    repeat (4) @(negedge clk);
    check(cnt_val == held, "R2", "unmapped write ignored", cnt_val, held);

    // R5: event up across the top
    phase = "R5";
    wr(2'd1, 16'hFFFC);
    @(negedge clk);
    wr(2'd0, ctlw(1, 1, 1, 0, 0));
    irqs = 0;
    repeat (5) begin pulse_a(); if (irq) irqs++; end
    @(negedge clk); if (irq) irqs++;
    check(cnt_val == 16'hFFFD, "R5", "up count wraps to reload", cnt_val, 16'hFFFD);
    check(irqs == 1, "R5", "one overflow interrupt", irqs, 1);
    // down across zero
    wr(2'd0, ctlw(1, 0, 0, 0, 0));
    wr(2'd1, 16'd2);
    @(negedge clk);
    wr(2'd0, ctlw(1, 1, 0, 0, 0));
    repeat (4) pulse_a();
    @(negedge clk);
    check(cnt_val == 16'd1, "R5", "down count wraps to reload", cnt_val, 1);

    // R6: quadrature, up bit set but ignored
    phase = "R6";
    wr(2'd0, ctlw(1, 0, 1, 1, 0));
    wr(2'd1, 16'h0010);
    @(negedge clk);
    wr(2'd0, ctlw(1, 1, 1, 1, 0));
    ext_b = 1'b0;
    repeat (3) pulse_a();
    ext_b = 1'b1;
    repeat (2) pulse_a();
    @(negedge clk);
    ext_b = 1'b0;
    check(cnt_val == 16'h0011, "R6", "quadrature net count", cnt_val, 16'h0011);

    // R7: one-shot with retrigger during the run
    phase = "R7";
    tick = 1'b1;
    wr(2'd0, ctlw(2, 0, 0, 0, 0));
    wr(2'd1, 16'd4);
    @(negedge clk);
    wr(2'd0, ctlw(2, 1, 0, 0, 0));
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    hits = 0; irqs = 0;
    for (int i = 0; i < 10; i++) begin
      if (pin_out) hits++;
      if (irq) irqs++;
      if (i == 1) trig = 1'b1;
      if (i == 2) trig = 1'b0;
      @(negedge clk);
    end
    check(hits == 4, "R7", "one-shot high ticks", hits, 4);
    check(irqs == 1, "R7", "one-shot completion irq", irqs, 1);

    // R8: 16-bit PWM, reload 3
    phase = "R8";
    wr(2'd0, ctlw(3, 0, 0, 0, 0));
    wr(2'd1, 16'd3);
    @(negedge clk);
    wr(2'd0, ctlw(3, 1, 0, 0, 0));
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    hits = 0; irqs = 0;
    for (int i = 0; i < 65545; i++) begin
      if (pin_out) hits++;
      if (irq) irqs++;
      @(negedge clk);
    end
    check(hits == 6, "R8", "16-bit PWM high count", hits, 6);
    check(irqs == 1, "R8", "16-bit PWM wrap irq", irqs, 1);

    // R9: 8-bit PWM, prescale 2, width 3
    phase = "R9";
    wr(2'd0, ctlw(3, 0, 0, 0, 1));
    wr(2'd1, 16'h0103);
    @(negedge clk);
    wr(2'd0, ctlw(3, 1, 0, 0, 1));
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    hits = 0; irqs = 0;
    for (int i = 0; i < 1020; i++) begin
      if (pin_out) hits++;
      if (irq) irqs++;
      @(negedge clk);
    end
    check(hits == 12, "R9", "8-bit PWM high count", hits, 12);
    check(irqs == 1, "R9", "8-bit PWM wrap irq", irqs, 1);

    // R3: stopping cancels PWM
    phase = "R3";
    wr(2'd0, ctlw(3, 0, 0, 0, 1));
    @(negedge clk);
    check(pin_out == 1'b0, "R3", "pin low after stop", pin_out, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule